// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Unit

This block collects the interrupt causes of one serial channel (line errors, received data, receive timeout, transmitter empty, modem line change, and two flow-control extensions) and turns them into one status byte that software reads to find the most urgent cause. It also drives a single interrupt line, which is high while any enabled cause is pending.

Some causes are levels and some are remembered events. The remembered events are cleared by the register accesses that service them: line status read, modem status read, receive data read and transmit data write. Two of them, transmitter empty and received Xoff, are cleared by reading the status byte itself. Such a read clears only the cause it reported. Lower-priority causes therefore appear one at a time on later reads.

The status byte is captured when a read begins and is held for the whole read. A cause that arrives during a read is kept for the next read.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, isrData[5:0] reads 000001 and irqOut is 0.
- R2: Bits 5:0 of the status report the highest-priority enabled pending cause, using these codes. From highest to lowest: line error 000110, receive timeout 001100, receive data 000100, transmitter empty 000010, modem change 000000, Xoff/special 010000, CTS/RTS change 100000. When no cause is pending, bits 5:1 read 0.
- R3: Bit 0 reads 0 exactly when some enabled cause is pending, and irqOut is its inverse. A cause whose enable bit is 0 is neither reported nor drives irqOut. The enable bits are: irqEn[0] receive data and timeout, [1] transmitter empty, [2] line error, [3] modem change, [4] Xoff, [5] CTS/RTS change.
- R4: During a status read (isrRd high), isrData shows the value from the cycle before isrRd rose and holds it until isrRd falls. A cause raised during the read is not lost.
- R5: The rising edge of isrRd clears the reported cause only when that cause is transmitter empty or Xoff. All other pending causes stay pending.
- R6: lsrRd clears the line error cause. msrRd clears both the modem change cause and the CTS/RTS change cause.
- R7: The receive data cause follows the rxDataLvl level. The receive timeout cause is cleared by rhrRd.
- R8: thrWr clears the transmitter empty cause. That cause is set by txEmptyEvt, or by irqEn[1] rising from 0 to 1 while txEmptyLvl is 1.
- R9: The Xoff and CTS/RTS change causes are set only while enhEn is 1. They are reported and drive irqOut only while enhEn is 1.
- R10: xonEvt clears the Xoff cause.
- R11: isrData[7:6] reads 11 when fifoEn is 1 and 00 when it is 0.
- R12: When a cause's set event and its clear strobe arrive in the same cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineErrEvt | input | 1 | Receiver line error event |
| rxDataLvl | input | 1 | Receive data at or above trigger level |
| rxTimeoutEvt | input | 1 | Receive timeout event |
| txEmptyEvt | input | 1 | Transmit holding register became empty |
| txEmptyLvl | input | 1 | Transmit holding register is empty |
| msrChangeEvt | input | 1 | Modem input change event |
| xoffEvt | input | 1 | Xoff or special character received |
| xonEvt | input | 1 | Matching Xon received |
| flowChangeEvt | input | 1 | CTS or RTS changed state |
| irqEn | input | 6 | Per-cause enable bits |
| enhEn | input | 1 | Enhanced-feature enable |
| fifoEn | input | 1 | FIFOs enabled |
| isrRd | input | 1 | Status register read strobe |
| lsrRd | input | 1 | Line status register read strobe |
| msrRd | input | 1 | Modem status register read strobe |
| rhrRd | input | 1 | Receive holding register read strobe |
| thrWr | input | 1 | Transmit holding register write strobe |
| isrData | output | 8 | Status read value |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a status read that overlaps a new, higher-priority cause. The read must still return the older code, clear only that code's cause, and expose the newer cause afterwards. The bench holds isrRd high for several cycles, injects a line error in the middle of the read, and then reads the status again. Priority coverage comes from sweeping every combination of the seven pending causes and every combination of enables with enhEn both set and cleared, comparing each result against an arithmetic priority model.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int SRC_W  = 6;
  localparam int STAT_W = 8;
  localparam int CODE_W = 6;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_XOFF  = 4;
  localparam int EN_FLOW  = 5;

  localparam logic [CODE_W-1:0] CODE_LINE  = 6'b000110;
  localparam logic [CODE_W-1:0] CODE_RXTO  = 6'b001100;
  localparam logic [CODE_W-1:0] CODE_RXDAT = 6'b000100;
  localparam logic [CODE_W-1:0] CODE_TX    = 6'b000010;
  localparam logic [CODE_W-1:0] CODE_MODEM = 6'b000000;
  localparam logic [CODE_W-1:0] CODE_XOFF  = 6'b010000;
  localparam logic [CODE_W-1:0] CODE_FLOW  = 6'b100000;
  localparam logic [CODE_W-1:0] CODE_IDLE  = 6'b000001;

  typedef struct packed {
    logic clrLine;
    logic clrTimeout;
    logic clrTx;
    logic clrModem;
    logic clrXoff;
    logic clrFlow;
    logic hold;
  } clrStrobe_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              isrRd,
  input  logic              lsrRd,
  input  logic              msrRd,
  input  logic              rhrRd,
  input  logic              thrWr,
  input  logic              xonEvt,
  input  logic [CODE_W-1:0] snapCode,
  output clrStrobe_t        strb
);
  logic isrRdQ;
  logic rdStart;
  logic snapPend;
  logic hitTx;
  logic hitXoff;

  always_ff @(posedge clk) begin
    if (!rstN) isrRdQ <= 1'b0;
    else       isrRdQ <= isrRd;
  end

  assign rdStart  = isrRd & ~isrRdQ;
  assign snapPend = ~snapCode[0];
  assign hitTx    = rdStart & snapPend & (snapCode == CODE_TX);
  assign hitXoff  = rdStart & snapPend & (snapCode == CODE_XOFF);

  always_comb begin
    strb            = '0;
    strb.hold       = isrRd;
    strb.clrLine    = lsrRd;
    strb.clrTimeout = rhrRd;
    strb.clrModem   = msrRd;
    strb.clrFlow    = msrRd;
    strb.clrTx      = thrWr | hitTx;
    strb.clrXoff    = xonEvt | hitXoff;
  end

  AST_ONE_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hitTx, hitXoff})); // R5
  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |=> !rdStart); // R4
endmodule

// File: rtl/uirq_dp.sv
module uirq_dp
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineErrEvt,
  input  logic              rxDataLvl,
  input  logic              rxTimeoutEvt,
  input  logic              txEmptyEvt,
  input  logic              txEmptyLvl,
  input  logic              msrChangeEvt,
  input  logic              xoffEvt,
  input  logic              flowChangeEvt,
  input  logic [SRC_W-1:0]  irqEn,
  input  logic              enhEn,
  input  logic              fifoEn,
  input  clrStrobe_t        strb,
  output logic [CODE_W-1:0] snapCode,
  output logic [STAT_W-1:0] isrData,
  output logic              irqOut
);
  logic lineP, toP, txP, modemP, xoffP, flowP;
  logic txEnQ;
  logic txSet, xoffSet, flowSet;
  logic [CODE_W-1:0] liveCode;
  logic [CODE_W-1:0] snapQ;

  assign txSet   = txEmptyEvt | (irqEn[EN_TX] & ~txEnQ & txEmptyLvl);
  assign xoffSet = xoffEvt & enhEn;
  assign flowSet = flowChangeEvt & enhEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineP  <= 1'b0;
      toP    <= 1'b0;
      txP    <= 1'b0;
      modemP <= 1'b0;
      xoffP  <= 1'b0;
      flowP  <= 1'b0;
      txEnQ  <= 1'b0;
    end else begin
      lineP  <= lineErrEvt    | (lineP  & ~strb.clrLine);
      toP    <= rxTimeoutEvt  | (toP    & ~strb.clrTimeout);
      txP    <= txSet         | (txP    & ~strb.clrTx);
      modemP <= msrChangeEvt  | (modemP & ~strb.clrModem);
      xoffP  <= xoffSet       | (xoffP  & ~strb.clrXoff);
      flowP  <= flowSet       | (flowP  & ~strb.clrFlow);
      txEnQ  <= irqEn[EN_TX];
    end
  end

  always_comb begin
    if      (lineP  & irqEn[EN_LINE])           liveCode = CODE_LINE;
    else if (toP    & irqEn[EN_RX])             liveCode = CODE_RXTO;
    else if (rxDataLvl & irqEn[EN_RX])          liveCode = CODE_RXDAT;
    else if (txP    & irqEn[EN_TX])             liveCode = CODE_TX;
    else if (modemP & irqEn[EN_MODEM])          liveCode = CODE_MODEM;
    else if (xoffP  & irqEn[EN_XOFF] & enhEn)   liveCode = CODE_XOFF;
    else if (flowP  & irqEn[EN_FLOW] & enhEn)   liveCode = CODE_FLOW;
    else                                        liveCode = CODE_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          snapQ <= CODE_IDLE;
    else if (!strb.hold) snapQ <= liveCode;
  end

  assign snapCode = snapQ;
  assign isrData  = {{2{fifoEn}}, strb.hold ? snapQ : liveCode};
  assign irqOut   = (lineP & irqEn[EN_LINE]) | ((toP | rxDataLvl) & irqEn[EN_RX])
                  | (txP & irqEn[EN_TX]) | (modemP & irqEn[EN_MODEM])
                  | (enhEn & ((xoffP & irqEn[EN_XOFF]) | (flowP & irqEn[EN_FLOW])));

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    liveCode[0] |-> (liveCode[5:1] == 5'b0)); // R2
  AST_LINE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLine && !lineErrEvt) |=> !lineP); // R6
  AST_TX_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrTx && !txSet) |=> !txP); // R8
  AST_XON_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrXoff && !xoffSet) |=> !xoffP); // R10
  AST_ENH_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!enhEn && !xoffP) |=> (!xoffP)); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hold && $past(strb.hold)) |-> $stable(snapQ)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    lineErrEvt |=> lineP); // R12
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineErrEvt,
  input  logic              rxDataLvl,
  input  logic              rxTimeoutEvt,
  input  logic              txEmptyEvt,
  input  logic              txEmptyLvl,
  input  logic              msrChangeEvt,
  input  logic              xoffEvt,
  input  logic              xonEvt,
  input  logic              flowChangeEvt,
  input  logic [5:0]        irqEn,
  input  logic              enhEn,
  input  logic              fifoEn,
  input  logic              isrRd,
  input  logic              lsrRd,
  input  logic              msrRd,
  input  logic              rhrRd,
  input  logic              thrWr,
  output logic [7:0]        isrData,
  output logic              irqOut
);
  clrStrobe_t        strb;
  logic [CODE_W-1:0] snapCode;

  uirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .isrRd(isrRd), .lsrRd(lsrRd), .msrRd(msrRd),
    .rhrRd(rhrRd), .thrWr(thrWr), .xonEvt(xonEvt), .snapCode(snapCode),
    .strb(strb)
  );

  uirq_dp u_dp (
    .clk(clk), .rstN(rstN), .lineErrEvt(lineErrEvt), .rxDataLvl(rxDataLvl),
    .rxTimeoutEvt(rxTimeoutEvt), .txEmptyEvt(txEmptyEvt), .txEmptyLvl(txEmptyLvl),
    .msrChangeEvt(msrChangeEvt), .xoffEvt(xoffEvt), .flowChangeEvt(flowChangeEvt),
    .irqEn(irqEn), .enhEn(enhEn), .fifoEn(fifoEn), .strb(strb),
    .snapCode(snapCode), .isrData(isrData), .irqOut(irqOut)
  );

  AST_IRQ_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    !isrRd |-> (irqOut == !isrData[0])); // R3
endmodule

// File: tb/test_uart_irq_status.sv
module test_uart_irq_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineErrEvt = 0, rxDataLvl = 0, rxTimeoutEvt = 0, txEmptyEvt = 0, txEmptyLvl = 0;
  logic msrChangeEvt = 0, xoffEvt = 0, xonEvt = 0, flowChangeEvt = 0;
  logic [5:0] irqEn = '0;
  logic enhEn = 0, fifoEn = 0;
  logic isrRd = 0, lsrRd = 0, msrRd = 0, rhrRd = 0, thrWr = 0;
  logic [7:0] isrData;
  logic irqOut;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_irq_status i_uart_irq_status (
    .clk(clk), .rstN(rstN), .lineErrEvt(lineErrEvt), .rxDataLvl(rxDataLvl),
    .rxTimeoutEvt(rxTimeoutEvt), .txEmptyEvt(txEmptyEvt), .txEmptyLvl(txEmptyLvl),
    .msrChangeEvt(msrChangeEvt), .xoffEvt(xoffEvt), .xonEvt(xonEvt),
    .flowChangeEvt(flowChangeEvt), .irqEn(irqEn), .enhEn(enhEn), .fifoEn(fifoEn),
    .isrRd(isrRd), .lsrRd(lsrRd), .msrRd(msrRd), .rhrRd(rhrRd), .thrWr(thrWr),
    .isrData(isrData), .irqOut(irqOut)
  );

  // p: 0 line, 1 timeout, 2 rx data, 3 tx, 4 modem, 5 xoff, 6 flow
  function automatic logic [5:0] expCode(input logic [6:0] p, input logic [5:0] en, input logic enh);
    if (p[0] && en[2])        return 6'b000110;
    if (p[1] && en[0])        return 6'b001100;
    if (p[2] && en[0])        return 6'b000100;
    if (p[3] && en[1])        return 6'b000010;
    if (p[4] && en[3])        return 6'b000000;
    if (p[5] && en[4] && enh) return 6'b010000;
    if (p[6] && en[5] && enh) return 6'b100000;
    return 6'b000001;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic setSrc(input logic [6:0] m);
    @(negedge clk);
    lineErrEvt = m[0]; rxTimeoutEvt = m[1]; rxDataLvl = m[2]; txEmptyEvt = m[3];
    msrChangeEvt = m[4]; xoffEvt = m[5]; flowChangeEvt = m[6];
    @(negedge clk);
    lineErrEvt = 0; rxTimeoutEvt = 0; txEmptyEvt = 0; msrChangeEvt = 0;
    xoffEvt = 0; flowChangeEvt = 0;
    #1;
  endtask

  task automatic clearAll();
    @(negedge clk);
    rxDataLvl = 0; lsrRd = 1; msrRd = 1; rhrRd = 1; thrWr = 1; xonEvt = 1;
    @(negedge clk);
    lsrRd = 0; msrRd = 0; rhrRd = 0; thrWr = 0; xonEvt = 0;
    #1;
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
    #1;
  endtask

  task automatic isrRead(output logic [7:0] v);
    @(negedge clk); isrRd = 1;
    #1 v = isrData;
    @(negedge clk); isrRd = 0;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check("R1 reset status", isrData, 8'b00000001);
    check("R1 reset irq", {7'b0, irqOut}, 8'd0);
    fifoEn = 1; #1;
    check("R11 fifo on", isrData, 8'b11000001);
    fifoEn = 0; #1;
    check("R11 fifo off", isrData, 8'b00000001);

    // R2 R3 sweep over all pending combinations
    irqEn = 6'h3F; enhEn = 1;
    for (int m = 0; m < 128; m++) begin
      logic [5:0] e;
      setSrc(m[6:0]);
      e = expCode(m[6:0], 6'h3F, 1'b1);
      check("R2 priority sweep", isrData, {2'b00, e});
      check("R3 irq sweep", {7'b0, irqOut}, {7'b0, ~e[0]});
      clearAll();
    end

    // R3 R9 sweep over enables with all causes pending
    setSrc(7'h7F);
    for (int k = 0; k < 128; k++) begin
      logic [5:0] e;
      @(negedge clk);
      irqEn = k[5:0]; enhEn = k[6];
      #1;
      e = expCode(7'h7F, k[5:0], k[6]);
      check("R3 R9 enable sweep", isrData, {2'b00, e});
      check("R3 enable irq", {7'b0, irqOut}, {7'b0, ~e[0]});
    end
    @(negedge clk); irqEn = 6'h3F; enhEn = 1;
    clearAll();
    check("R6 R7 R8 R10 all cleared", isrData, 8'b00000001);

    // R5: tx cleared by status read, modem stays
    setSrc(7'b0011000);
    isrRead(v);
    check("R5 read tx code", v, 8'b00000010);
    #1 check("R5 modem remains", isrData, 8'b00000000);
    isrRead(v);
    check("R5 read modem code", v, 8'b00000000);
    check("R5 modem not cleared by read", isrData, 8'b00000000);
    strobe(msrRd);
    check("R6 msr clears modem", isrData, 8'b00000001);

    // R5 R10 xoff cleared by read, then by xon
    setSrc(7'b0100000);
    isrRead(v);
    check("R5 read xoff code", v, 8'b00010000);
    check("R5 xoff cleared by read", isrData, 8'b00000001);
    setSrc(7'b0100000);
    strobe(xonEvt);
    check("R10 xon clears xoff", isrData, 8'b00000001);

    // R6 line and flow
    setSrc(7'b1000001);
    check("R6 line pending", isrData, 8'b00000110);
    strobe(lsrRd);
    check("R6 lsr clears line", isrData, 8'b00100000);
    strobe(msrRd);
    check("R6 msr clears flow", isrData, 8'b00000001);

    // R7 timeout and data level
    setSrc(7'b0000110);
    check("R7 timeout", isrData, 8'b00001100);
    strobe(rhrRd);
    check("R7 rhr clears timeout", isrData, 8'b00000100);
    @(negedge clk); rxDataLvl = 0; #1;
    check("R7 data follows level", isrData, 8'b00000001);

    // R8 thr write and enable re-arm
    setSrc(7'b0001000);
    strobe(thrWr);
    check("R8 thr write clears", isrData, 8'b00000001);
    @(negedge clk); irqEn[1] = 0; txEmptyLvl = 1;
    @(negedge clk); irqEn[1] = 1;
    @(negedge clk); #1;
    check("R8 rearm on enable rise", isrData, 8'b00000010);
    @(negedge clk); txEmptyLvl = 0;
    clearAll();

    // R9 no set while enhanced off
    @(negedge clk); enhEn = 0;
    setSrc(7'b1100000);
    @(negedge clk); enhEn = 1; #1;
    check("R9 not set when disabled", isrData, 8'b00000001);
    check("R9 irq low", {7'b0, irqOut}, 8'd0);

    // R4 snapshot held while a new cause arrives
    setSrc(7'b0001000);
    @(negedge clk); isrRd = 1; #1;
    check("R4 snapshot", isrData, 8'b00000010);
    @(negedge clk); lineErrEvt = 1;
    @(negedge clk); lineErrEvt = 0; #1;
    check("R4 held during read", isrData, 8'b00000010);
    check("R4 irq reflects new cause", {7'b0, irqOut}, 8'd1);
    @(negedge clk); isrRd = 0; #1;
    check("R4 new cause kept", isrData, 8'b00000110);
    strobe(lsrRd);
    check("R5 tx cleared by overlapped read", isrData, 8'b00000001);

    // R12 set wins over clear
    @(negedge clk); lineErrEvt = 1; lsrRd = 1;
    @(negedge clk); lineErrEvt = 0; lsrRd = 0; #1;
    check("R12 set wins", isrData, 8'b00000110);
    clearAll();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule